// File: doc/BRIEF.md
# Ethernet Transmit Buffer with Collision Retry

This block sits between a word-wide packet source and the transmit side of a half-duplex CSMA/CD Ethernet MAC. The source writes 32-bit words of packet data and marks the final word of each packet. The block holds those words and decides when to begin a frame. It then streams the preamble, the start-of-frame delimiter and the packet bytes to the MAC, one byte per handshake.

A frame is started once more words are waiting than a programmed threshold, or as soon as a whole packet is present. In either case the block first waits for the line-busy input to go low. While the frame is inside its collision window, the packet's words stay in the buffer. A collision in that window rewinds the frame to its first byte. The block then waits for an external backoff timer and tries again. When the attempt count reaches the programmed maximum, the packet is discarded and a sticky excessive-collision flag is raised. Once the window closes, the buffer space under the bytes already sent is given back to the writer.

Both streams use valid/ready handshakes. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverse of the full flag, and a write offered while it is low is dropped. A byte is taken on an edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. `tx_valid` may fall in the middle of a packet if the writer has not yet supplied the next word.

Top module: `eth_tx_retry_fifo`

## Requirements
- R1: Storage holds 128 words of 32 bits (512 bytes). `wr_ready` is low while 128 words are held and not yet released. A write offered while `wr_ready` is low changes neither the buffer nor the transmitted data.
- R2: With `cfg_le`=0, the first byte sent from a word is `wr_data[31:24]` and the last is `wr_data[7:0]`. With `cfg_le`=1, the order is reversed: `wr_data[7:0]` goes first. On a word marked last, `wr_bytes_m1` gives the number of valid bytes minus one, and these are the first bytes in the order above.
- R3: A frame becomes eligible when the number of words written since the packet's first word is greater than `cfg_thresh`, or when the packet's last word has been written.
- R4: An eligible frame does not start while `line_busy` is high.
- R5: Each frame is seven bytes of 0x55, then one 0xD5 byte, then the packet bytes in order. `tx_last` is high only with the final packet byte.
- R6: A collision (`col_in` high) while fewer than `cfg_colwin` frame bytes, counting preamble and delimiter, have been accepted aborts the frame. `backoff_req` then stays high until a `bo_done` pulse. After that, the frame is resent from the first preamble byte, and line busy is checked again before it starts.
- R7: A collision after `cfg_colwin` frame bytes have been accepted has no effect. The frame continues and no backoff is requested.
- R8: When a collision aborts the `cfg_max_ret`-th attempt of a packet, the packet is discarded without further transmission and `exc_col` goes high. `exc_col` stays high until the first attempt of the next packet starts.
- R9: `cfg_err` is high exactly when 4*`cfg_thresh` + 8 < `cfg_colwin`.
- R10: Words of the frame being sent are released to the writer only after the collision window has passed. A full buffer does not regain `wr_ready` while fewer than `cfg_colwin` bytes have gone out, and it does regain it once the window is past.
- R11: While `tx_valid` is high and `tx_ready` is low, with no collision, `tx_valid` stays high and `tx_data` is unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_le | input | 1 | Static byte order of the write port: 1 = little endian |
| cfg_thresh | input | 8 | Start threshold in words |
| cfg_colwin | input | 8 | Collision window in bytes, including preamble and SFD |
| cfg_max_ret | input | 4 | Maximum number of attempts per packet |
| cfg_err | output | 1 | Threshold too small for the collision window |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Buffer not full |
| wr_data | input | 32 | Packet word |
| wr_last | input | 1 | Word is the final word of its packet |
| wr_bytes_m1 | input | 2 | Valid bytes minus one in the final word |
| line_busy | input | 1 | Medium carries traffic |
| col_in | input | 1 | Collision seen on the medium |
| bo_done | input | 1 | Backoff timer expired (pulse) |
| backoff_req | output | 1 | Waiting for backoff to expire |
| exc_col | output | 1 | Sticky: last packet discarded after too many collisions |
| tx_valid | output | 1 | Byte offered to the MAC |
| tx_ready | input | 1 | MAC takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final packet byte |

## Verification
The hardest path to reach is the discard after the retry limit. Every attempt of one packet must collide inside its window, and each backoff must be answered. The bench gets there by tying `col_in` to `tx_valid` for the span of one packet, while a background responder answers each `backoff_req` with a `bo_done` pulse a few cycles later. The release of space after the window needs a full buffer held back by `line_busy`. The bench samples `wr_ready` at two byte counts, one below the window and one above it.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SFD,
    S_DATA,
    S_BACK,
    S_DROP
  } txf_state_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [2:0] PRE_LAST = 3'd6;
endpackage

// File: rtl/txf_buf.sv
module txf_buf #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_le,
  input  logic          wr_valid,
  input  logic [31:0]   wr_data,
  input  logic          wr_last,
  input  logic [1:0]    wr_bytes_m1,
  input  logic [AW:0]   base_ptr,
  input  logic [AW:0]   rd_ptr,
  output logic          wr_ready,
  output logic [AW:0]   wr_ptr,
  output logic          wr_acc_last,
  output logic [31:0]   rd_word,
  output logic          rd_last,
  output logic [1:0]    rd_bytes_m1
);
  localparam int SW = 35;

  logic [SW-1:0] mem [DEPTH];
  logic [AW:0]   used;
  logic [31:0]   swapped;
  logic [31:0]   be_word;
  logic          wr_acc;

  // byte reversal for little-endian writers
  for (genvar g = 0; g < 4; g++) begin : g_swap
    assign swapped[8*g +: 8] = wr_data[8*(3-g) +: 8];
  end

  assign be_word     = cfg_le ? swapped : wr_data;
  assign used        = wr_ptr - base_ptr;
  assign wr_ready    = !used[AW];
  assign wr_acc      = wr_valid && wr_ready;
  assign wr_acc_last = wr_acc && wr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_bytes_m1, be_word};
  end

  assign {rd_last, rd_bytes_m1, rd_word} = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int AW = 7,
  parameter int CW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wr_ptr,
  input  logic          wr_acc_last,
  input  logic [31:0]   rd_word,
  input  logic          rd_last,
  input  logic [1:0]    rd_bytes_m1,
  input  logic [AW:0]   cfg_thresh,
  input  logic [CW-1:0] cfg_colwin,
  input  logic [RW-1:0] cfg_max_ret,
  input  logic          line_busy,
  input  logic          col_in,
  input  logic          bo_done,
  input  logic          tx_ready,
  output txf_state_e    st,
  output logic [AW:0]   rd_ptr,
  output logic [AW:0]   start_ptr,
  output logic [AW:0]   base_ptr,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          backoff_req,
  output logic          exc_col,
  output logic          col_abort
);
  logic [2:0]    pre_cnt;
  logic [1:0]    byte_idx;
  logic [CW-1:0] sent;
  logic [RW-1:0] tries;
  logic [AW:0]   pkt_cnt;
  logic [AW:0]   pend;
  logic          in_tx, avail, eligible, win_ok, last_try;
  logic          hs, word_end, pkt_done;
  logic [7:0]    data_byte;

  assign in_tx    = (st == S_PRE) || (st == S_SFD) || (st == S_DATA);
  assign avail    = rd_ptr != wr_ptr;
  assign pend     = wr_ptr - start_ptr;
  assign eligible = (pkt_cnt != '0) || (pend > cfg_thresh);
  assign win_ok   = sent >= cfg_colwin;
  assign col_abort = in_tx && col_in && !win_ok;
  assign last_try = ({1'b0, tries} + 1'b1) >= {1'b0, cfg_max_ret};

  always_comb begin
    case (byte_idx)
      2'd0:    data_byte = rd_word[31:24];
      2'd1:    data_byte = rd_word[23:16];
      2'd2:    data_byte = rd_word[15:8];
      default: data_byte = rd_word[7:0];
    endcase
  end

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = data_byte;
    case (st)
      S_PRE:  begin tx_valid = 1'b1; tx_data = PRE_BYTE; end
      S_SFD:  begin tx_valid = 1'b1; tx_data = SFD_BYTE; end
      S_DATA: tx_valid = avail;
      default: ;
    endcase
  end

  assign tx_last     = (st == S_DATA) && avail && rd_last && (byte_idx == rd_bytes_m1);
  assign hs          = tx_valid && tx_ready;
  assign word_end    = (byte_idx == 2'd3) || (rd_last && (byte_idx == rd_bytes_m1));
  assign pkt_done    = ((st == S_DATA) && hs && tx_last && !col_abort) ||
                       ((st == S_DROP) && avail && rd_last);
  assign base_ptr    = ((st == S_DROP) || (in_tx && win_ok)) ? rd_ptr : start_ptr;
  assign backoff_req = st == S_BACK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_ptr    <= '0;
      start_ptr <= '0;
      pre_cnt   <= '0;
      byte_idx  <= '0;
      sent      <= '0;
      tries     <= '0;
      pkt_cnt   <= '0;
      exc_col   <= 1'b0;
    end else begin
      pkt_cnt <= pkt_cnt + {{AW{1'b0}}, wr_acc_last} - {{AW{1'b0}}, pkt_done};

      if (st == S_IDLE) sent <= '0;
      else if (in_tx && hs && !(&sent)) sent <= sent + 1'b1;

      if (col_abort) begin
        rd_ptr   <= start_ptr;
        byte_idx <= '0;
        if (last_try) begin
          st      <= S_DROP;
          exc_col <= 1'b1;
          tries   <= '0;
        end else begin
          st    <= S_BACK;
          tries <= tries + 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: if (eligible && !line_busy) begin
            st       <= S_PRE;
            pre_cnt  <= '0;
            byte_idx <= '0;
            if (tries == '0) exc_col <= 1'b0;
          end
          S_PRE: if (hs) begin
            pre_cnt <= pre_cnt + 1'b1;
            if (pre_cnt == PRE_LAST) st <= S_SFD;
          end
          S_SFD: if (hs) st <= S_DATA;
          S_DATA: if (hs) begin
            if (tx_last) begin
              st        <= S_IDLE;
              rd_ptr    <= rd_ptr + 1'b1;
              start_ptr <= rd_ptr + 1'b1;
              tries     <= '0;
              byte_idx  <= '0;
            end else if (word_end) begin
              rd_ptr   <= rd_ptr + 1'b1;
              byte_idx <= '0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
            end
          end
          S_BACK: if (bo_done) st <= S_IDLE;
          S_DROP: if (avail) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (rd_last) begin
              st        <= S_IDLE;
              start_ptr <= rd_ptr + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eth_tx_retry_fifo.sv
module eth_tx_retry_fifo
  import txf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int RW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_le,
  input  logic [$clog2(DEPTH):0]     cfg_thresh,
  input  logic [CW-1:0]              cfg_colwin,
  input  logic [RW-1:0]              cfg_max_ret,
  output logic                       cfg_err,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [31:0]                wr_data,
  input  logic                       wr_last,
  input  logic [1:0]                 wr_bytes_m1,
  input  logic                       line_busy,
  input  logic                       col_in,
  input  logic                       bo_done,
  output logic                       backoff_req,
  output logic                       exc_col,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [7:0]                 tx_data,
  output logic                       tx_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = ((AW + 3) > CW ? (AW + 3) : CW) + 1;

  txf_state_e  st_w;
  logic [AW:0] wr_ptr_w, rd_ptr_w, start_ptr_w, base_ptr_w;
  logic        wr_acc_last_w, rd_last_w, col_abort_w;
  logic [31:0] rd_word_w;
  logic [1:0]  rd_bytes_m1_w;
  logic [EW-1:0] thr_bytes, win_bytes;

  // threshold in bytes plus the 8 framing bytes must cover the window
  assign thr_bytes = EW'({cfg_thresh, 2'b00}) + EW'(8);
  assign win_bytes = EW'(cfg_colwin);
  assign cfg_err   = thr_bytes < win_bytes;

  txf_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_le      (cfg_le),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .wr_last     (wr_last),
    .wr_bytes_m1 (wr_bytes_m1),
    .base_ptr    (base_ptr_w),
    .rd_ptr      (rd_ptr_w),
    .wr_ready    (wr_ready),
    .wr_ptr      (wr_ptr_w),
    .wr_acc_last (wr_acc_last_w),
    .rd_word     (rd_word_w),
    .rd_last     (rd_last_w),
    .rd_bytes_m1 (rd_bytes_m1_w)
  );

  txf_ctrl #(.AW(AW), .CW(CW), .RW(RW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ptr      (wr_ptr_w),
    .wr_acc_last (wr_acc_last_w),
    .rd_word     (rd_word_w),
    .rd_last     (rd_last_w),
    .rd_bytes_m1 (rd_bytes_m1_w),
    .cfg_thresh  (cfg_thresh),
    .cfg_colwin  (cfg_colwin),
    .cfg_max_ret (cfg_max_ret),
    .line_busy   (line_busy),
    .col_in      (col_in),
    .bo_done     (bo_done),
    .tx_ready    (tx_ready),
    .st          (st_w),
    .rd_ptr      (rd_ptr_w),
    .start_ptr   (start_ptr_w),
    .base_ptr    (base_ptr_w),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .backoff_req (backoff_req),
    .exc_col     (exc_col),
    .col_abort   (col_abort_w)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk
  import txf_pkg::*;
#(
  parameter int AW = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr,
  input logic [AW:0] start_ptr,
  input txf_state_e  st,
  input logic        line_busy,
  input logic        col_in,
  input logic        col_abort,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        exc_col
);
  // R1: a write offered while full is dropped
  a_r1_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_ptr));

  // R4: no frame start while the line is busy
  a_r4_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && line_busy) |=> (st != S_PRE));

  // R5: preamble bytes carry 0x55
  a_r5_preamble_value: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && tx_valid) |-> (tx_data == 8'h55));

  // R5: last marker only on a packet byte
  a_r5_last_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (st == S_DATA && tx_valid));

  // R6: an abort rewinds to the packet's first word
  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    col_abort |=> (rd_ptr == start_ptr && st != S_DATA));

  // R8: excessive-collision flag rises only when a packet is dropped
  a_r8_exc_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_col) |-> (st == S_DROP));

  // R11: byte held under back-pressure
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !col_in) |=> (tx_valid && $stable(tx_data)));
endmodule

bind eth_tx_retry_fifo txf_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_ptr    (wr_ptr_w),
  .rd_ptr    (rd_ptr_w),
  .start_ptr (start_ptr_w),
  .st        (st_w),
  .line_busy (line_busy),
  .col_in    (col_in),
  .col_abort (col_abort_w),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .exc_col   (exc_col)
);

// File: tb/sim_eth_tx_retry_fifo.sv
`timescale 1ns/1ps
module sim_eth_tx_retry_fifo;
  localparam int AW = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_le;
  logic [AW:0] cfg_thresh;
  logic [7:0]  cfg_colwin;
  logic [3:0]  cfg_max_ret;
  logic        cfg_err;
  logic        wr_valid, wr_ready, wr_last;
  logic [31:0] wr_data;
  logic [1:0]  wr_bytes_m1;
  logic        line_busy, col_in, bo_done, backoff_req, exc_col;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;

  logic        col_pulse = 1'b0, col_auto = 1'b0, late_ok = 1'b0;
  int          rdy_mode = 0;
  int          checks = 0, errors = 0;
  int          nlast = 0, nbo = 0;
  logic        bo_prev = 1'b0;
  logic [7:0]  rx[$];
  logic [7:0]  expq[$];
  bit          done = 0;

  always #2 clk = ~clk;

  assign col_in = col_pulse | (col_auto & tx_valid);

  eth_tx_retry_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_le(cfg_le), .cfg_thresh(cfg_thresh),
    .cfg_colwin(cfg_colwin), .cfg_max_ret(cfg_max_ret), .cfg_err(cfg_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .wr_bytes_m1(wr_bytes_m1), .line_busy(line_busy), .col_in(col_in),
    .bo_done(bo_done), .backoff_req(backoff_req), .exc_col(exc_col),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  // byte capture and backoff counting, away from the active edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && (!col_in || late_ok)) begin
      rx.push_back(tx_data);
      if (tx_last) nlast++;
    end
    if (backoff_req && !bo_prev) nbo++;
    bo_prev = backoff_req;
  end

  // MAC ready pattern
  initial begin
    int cyc = 0;
    tx_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready = (rdy_mode == 0) || (cyc % 3 != 0);
    end
  end

  // backoff timer stand-in
  initial begin
    bo_done = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (backoff_req) begin
        repeat (3) @(posedge clk);
        #1 bo_done = 1'b1;
        @(posedge clk); #1 bo_done = 1'b0;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pb(int seed, int i);
    return 8'((seed * 13 + i * 37 + 5) & 255);
  endfunction

  task automatic start_exp();
    expq.delete();
    for (int i = 0; i < 7; i++) expq.push_back(8'h55);
    expq.push_back(8'hD5);
  endtask

  task automatic put_word(logic [31:0] d, logic last, logic [1:0] nb);
    bit acc;
    wr_data = d; wr_last = last; wr_bytes_m1 = nb; wr_valid = 1'b1;
    forever begin
      @(negedge clk); acc = wr_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    wr_valid = 1'b0;
  endtask

  // word w of an n-byte packet; R2 ordering computed here
  task automatic put_w(int seed, int n, int w);
    logic [31:0] be, le;
    int nw = (n + 3) / 4;
    be = '0; le = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = (4*w + k < n) ? pb(seed, 4*w + k) : 8'h00;
      be[31 - 8*k -: 8] = b;
      le[8*k +: 8] = b;
      if (4*w + k < n) expq.push_back(b);
    end
    put_word(cfg_le ? le : be, (w == nw - 1), (w == nw - 1) ? 2'(n - 1 - 4*w) : 2'd3);
  endtask

  task automatic put_pkt(int seed, int n);
    start_exp();
    for (int w = 0; w < (n + 3) / 4; w++) put_w(seed, n, w);
  endtask

  task automatic wait_last(int target);
    while (nlast < target) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic cmp_frame(string req, bit exact);
    int l = expq.size();
    int off = rx.size() - l;
    int bad = 0;
    chk(off >= 0 && (!exact || off == 0), req, "frame length", rx.size(), l);
    if (off >= 0)
      for (int i = 0; i < l; i++) if (rx[off + i] != expq[i]) bad++;
    chk(bad == 0, req, "frame byte mismatches", bad, 0);
    rx.delete();
  endtask

  task automatic wait_rx(int n);
    while (rx.size() < n) @(posedge clk);
    #1;
  endtask

  initial begin
    int t, b0;
    rst_n = 1'b0; cfg_le = 1'b0; cfg_thresh = 8'd2; cfg_colwin = 8'd16;
    cfg_max_ret = 4'd3; wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0;
    wr_bytes_m1 = '0; line_busy = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "reset", "tx_valid", tx_valid, 0);
    chk(wr_ready, "reset R1", "wr_ready", wr_ready, 1);
    chk(!exc_col && !backoff_req, "reset R8", "exc/backoff", exc_col, 0);
    @(posedge clk); #1;

    // R2 R5 R11: byte order and framing under two ready patterns
    for (int le = 0; le < 2; le++)
      for (int rm = 0; rm < 2; rm++)
        for (int n = 1; n <= 9; n++) begin
          cfg_le = le[0]; rdy_mode = rm;
          t = nlast + 1;
          put_pkt(le * 100 + rm * 20 + n, n);
          wait_last(t);
          cmp_frame(le ? "R2 R5 R11 le" : "R2 R5 R11 be", 1);
        end
    rdy_mode = 0; cfg_le = 1'b0;

    // R9: configuration rule sweep
    for (int th = 0; th <= 4; th++)
      for (int cw = 8; cw <= 28; cw += 4) begin
        cfg_thresh = 8'(th); cfg_colwin = 8'(cw); #1;
        chk(cfg_err == (th * 4 + 8 < cw), "R9", "cfg_err", cfg_err, int'(th * 4 + 8 < cw));
      end
    cfg_thresh = 8'd3; cfg_colwin = 8'd16;
    @(posedge clk); #1;

    // R3: threshold start before the packet is complete
    start_exp();
    t = nlast + 1;
    for (int w = 0; w < 3; w++) put_w(7, 20, w);
    repeat (10) @(posedge clk);
    #1 chk(!tx_valid, "R3", "start at threshold", tx_valid, 0);
    put_w(7, 20, 3);
    repeat (3) @(posedge clk);
    #1 chk(tx_valid, "R3", "start above threshold", tx_valid, 1);
    put_w(7, 20, 4);
    wait_last(t);
    cmp_frame("R3", 1);

    // R4: line busy holds the start
    line_busy = 1'b1;
    t = nlast + 1;
    put_pkt(9, 6);
    repeat (10) @(posedge clk);
    #1 chk(!tx_valid, "R4", "tx_valid while busy", tx_valid, 0);
    line_busy = 1'b0;
    wait_last(t);
    cmp_frame("R4", 1);

    // R6: collisions inside the window, in preamble and in data
    for (int at = 3; at <= 10; at += 7) begin
      b0 = nbo; t = nlast + 1;
      put_pkt(30 + at, 12);
      wait_rx(at);
      col_pulse = 1'b1; @(posedge clk); #1 col_pulse = 1'b0;
      wait_last(t);
      chk(nbo - b0 == 1, "R6", "backoff requests", nbo - b0, 1);
      chk(rx.size() > expq.size(), "R6", "bytes incl. aborted attempt", rx.size(), expq.size() + at);
      cmp_frame("R6", 0);
    end

    // R7: collision after the window is ignored
    b0 = nbo; t = nlast + 1;
    put_pkt(44, 20);
    wait_rx(20);
    late_ok = 1'b1; col_pulse = 1'b1;
    @(posedge clk); #1 col_pulse = 1'b0;
    @(negedge clk); late_ok = 1'b0;
    wait_last(t);
    chk(nbo == b0, "R7", "backoff requests", nbo - b0, 0);
    cmp_frame("R7", 1);

    // R8: every attempt collides, packet discarded
    b0 = nbo; col_auto = 1'b1;
    put_pkt(55, 8);
    while (!exc_col) @(posedge clk);
    #1 col_auto = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(exc_col, "R8", "exc_col sticky", exc_col, 1);
    chk(nbo - b0 == 2, "R8", "backoffs before drop", nbo - b0, 2);
    chk(rx.size() == 0 && !tx_valid, "R8", "bytes from dropped packet", rx.size(), 0);
    rx.delete();
    t = nlast + 1;
    put_pkt(66, 5);
    wait_last(t);
    cmp_frame("R8", 1);
    chk(!exc_col, "R8", "exc_col cleared by next packet", exc_col, 0);

    // R1 R10: fill, dropped write, release after the window
    line_busy = 1'b1; t = nlast + 1;
    start_exp();
    for (int w = 0; w < 128; w++) put_w(77, 512, w);
    #1 chk(!wr_ready, "R1", "wr_ready when full", wr_ready, 0);
    wr_data = 32'hDEADBEEF; wr_last = 1'b1; wr_bytes_m1 = 2'd0; wr_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 wr_valid = 1'b0;
    chk(!wr_ready, "R1", "wr_ready after dropped write", wr_ready, 0);
    line_busy = 1'b0;
    wait_rx(12);
    chk(!wr_ready, "R10", "wr_ready inside window", wr_ready, 0);
    wait_rx(24);
    chk(wr_ready, "R10", "wr_ready after window", wr_ready, 1);
    wait_last(t);
    cmp_frame("R1", 1);
    repeat (20) @(posedge clk);
    #1 chk(!tx_valid && nlast == t, "R1", "no frame from dropped write", nlast, t);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule